// File: doc/BRIEF.md
# Memory Write-Protection Controller

This block sits between the serial command decoder of a 16K x 8 nonvolatile memory and its self-timed write engine. It decides, for every nonvolatile write the decoder asks for, whether the write may go ahead. It keeps the protection state: a write enable latch, two block-protect bits that fence off none, the top quarter, the top half or all of the array, and a write-protect-enable bit. When that bit is set, the external write-protect pin guards the status register.

Array writes are decided in the cycle they are requested. A status-register write is armed when it is requested inside a frame (chip select low). It is committed only when the frame closes. If the write-protect pin falls while the frame is still open, the armed write is cancelled. Once the commit has happened and the write engine reports busy, the pin has no further effect. Each decision appears as a one-cycle grant or deny pulse. The status byte is always presented for readback.

Top module: `nvm_write_guard`

## Requirements
- R1: After reset the status byte is 0x00 apart from bit 0, which follows `busy`, and no grant or deny pulse is produced.
- R2: `wel_set` sets the write enable latch and `wel_clr` clears it. When both are high in the same cycle, clear wins. The latch is visible in status bit 1 one cycle after the command.
- R3: Any write requested while the latch is clear is denied.
- R4: Block-protect code `bp` (status bits 3:2) decides array write refusal. Code 00 protects nothing. Code 01 protects addresses 0x3000-0x3FFF. Code 10 protects 0x2000-0x3FFF. Code 11 protects the whole array. A write to a protected address is denied.
- R5: When `wp_n` is low and the enable bit (status bit 7) is 1, a status-register write request is denied. Array writes are not affected by `wp_n`.
- R6: When the enable bit is 0, `wp_n` is ignored. A status write is then accepted even with `wp_n` held low.
- R7: A falling edge on `wp_n` while `sel_n` is low and a status write is armed, with the enable bit at 1, cancels the write. The cancellation gives a deny pulse one cycle after the fall.
- R8: Once a status write has committed and the engine is busy, a later `wp_n` fall produces no pulse and leaves the protection fields unchanged.
- R9: While `busy` is high, status-register and array write requests are denied, and a commit falling in a busy cycle is denied.
- R10: The write enable latch is clear in the cycle that any grant or deny pulse is visible. A decision overrides a same-cycle `wel_set`.
- R11: The status byte layout is: bit 7 enable, bits 6:4 zero, bits 3:2 block-protect code, bit 1 latch, bit 0 `busy`.
- R12: An armed status write commits when `sel_n` rises. The grant pulse and the new fields (enable from data bit 7, code from data bits 3:2) appear one cycle after the rise. A grant and a deny are never given together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| sel_n | input | 1 | Chip select, low while a frame is open |
| wp_n | input | 1 | Write-protect pin, low protects |
| busy | input | 1 | Self-timed write engine busy |
| wel_set | input | 1 | Set write enable latch |
| wel_clr | input | 1 | Clear write enable latch |
| sr_wr_req | input | 1 | Status-register write request |
| sr_wr_data | input | 8 | Status write data |
| arr_wr_req | input | 1 | Array write request |
| arr_addr | input | ADDR_W | Array byte address |
| sr_grant | output | 1 | Status write granted (pulse) |
| sr_deny | output | 1 | Status write refused or cancelled (pulse) |
| arr_grant | output | 1 | Array write granted (pulse) |
| arr_deny | output | 1 | Array write refused (pulse) |
| status | output | 8 | Status byte |

## Verification
A wrong latch value shows at status bit 1 one cycle after the command. It then shows as a wrong grant or deny pulse at the very next write request. A corrupted block-protect code or enable bit is visible at once in the status byte. It also flips the decision on a boundary address such as 0x2FFF/0x3000 or 0x1FFF/0x2000. An armed status write that was lost or wrongly kept shows as a missing deny on the cycle after a `wp_n` fall, or as a missing grant on the cycle after `sel_n` rises.

// File: rtl/nvm_write_guard.sv
module nvm_write_guard #(
  parameter int ADDR_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n,
  input  logic              wp_n,
  input  logic              busy,
  input  logic              wel_set,
  input  logic              wel_clr,
  input  logic              sr_wr_req,
  input  logic [7:0]        sr_wr_data,
  input  logic              arr_wr_req,
  input  logic [ADDR_W-1:0] arr_addr,
  output logic              sr_grant,
  output logic              sr_deny,
  output logic              arr_grant,
  output logic              arr_deny,
  output logic [7:0]        status
);

  logic       wpen, wel, pend, wp_q, sel_q;
  logic [1:0] bp, pend_bp;
  logic       pend_wpen;

  logic prot;
  always_comb begin
    case (bp)
      2'b00:   prot = 1'b0;
      2'b01:   prot = &arr_addr[ADDR_W-1 -: 2];
      2'b10:   prot = arr_addr[ADDR_W-1];
      default: prot = 1'b1;
    endcase
  end

  wire wp_fall   = wp_q & ~wp_n;
  wire frame_end = ~sel_q & sel_n;
  wire wp_lock   = wpen & ~wp_n;

  wire sr_reject  = sr_wr_req & ~pend & (busy | ~wel | wp_lock);
  wire sr_accept  = sr_wr_req & ~pend & ~sr_reject;
  wire abort      = pend & wpen & wp_fall & ~sel_n;
  wire commit     = pend & frame_end & ~abort;
  wire commit_ok  = commit & wel & ~busy & ~wp_lock;
  wire commit_bad = commit & ~commit_ok;
  wire arr_ok     = arr_wr_req & wel & ~busy & ~prot;
  wire arr_bad    = arr_wr_req & ~arr_ok;
  wire decided    = sr_reject | abort | commit | arr_wr_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wpen      <= 1'b0;
      bp        <= 2'b00;
      wel       <= 1'b0;
      pend      <= 1'b0;
      pend_wpen <= 1'b0;
      pend_bp   <= 2'b00;
      wp_q      <= 1'b1;
      sel_q     <= 1'b1;
      sr_grant  <= 1'b0;
      sr_deny   <= 1'b0;
      arr_grant <= 1'b0;
      arr_deny  <= 1'b0;
    end else begin
      wp_q      <= wp_n;
      sel_q     <= sel_n;
      sr_grant  <= commit_ok;
      sr_deny   <= sr_reject | abort | commit_bad;
      arr_grant <= arr_ok;
      arr_deny  <= arr_bad;

      if (decided || wel_clr) wel <= 1'b0;
      else if (wel_set)       wel <= 1'b1;

      if (sr_accept) begin
        pend      <= 1'b1;
        pend_wpen <= sr_wr_data[7];
        pend_bp   <= sr_wr_data[3:2];
      end else if (abort || commit) begin
        pend <= 1'b0;
      end

      if (commit_ok) begin
        wpen <= pend_wpen;
        bp   <= pend_bp;
      end
    end
  end

  assign status = {wpen, 3'b000, bp, wel, busy};

endmodule

module nvm_write_guard_chk #(
  parameter int ADDR_W = 14
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic [ADDR_W-1:0] arr_addr,
  input logic              sr_grant,
  input logic              sr_deny,
  input logic              arr_grant,
  input logic              arr_deny,
  input logic [7:0]        status
);

  assert_latch_needed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_grant | arr_grant) |-> $past(status[1]));

  assert_latch_cleared_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_grant | sr_deny | arr_grant | arr_deny) |-> !status[1]);

  assert_busy_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_grant | arr_grant) |-> !$past(busy));

  assert_layout_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (status[6:4] == 3'b000) && (status[0] == busy));

  assert_block_fence_R4: assert property (@(posedge clk) disable iff (!rst_n)
    arr_grant |-> !(($past(status[3:2]) == 2'b11) ||
                    ($past(status[3:2]) == 2'b10 && $past(arr_addr[ADDR_W-1])) ||
                    ($past(status[3:2]) == 2'b01 && $past(&arr_addr[ADDR_W-1 -: 2]))));

  assert_one_answer_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sr_grant, sr_deny}) && $onehot0({arr_grant, arr_deny}));

  assert_fields_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !sr_grant |-> $stable({status[7], status[3:2]}));

endmodule

bind nvm_write_guard nvm_write_guard_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .arr_addr(arr_addr),
  .sr_grant(sr_grant), .sr_deny(sr_deny), .arr_grant(arr_grant),
  .arr_deny(arr_deny), .status(status)
);

// File: tb/tb_nvm_write_guard.sv
module tb_nvm_write_guard;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sel_n = 1'b1, wp_n = 1'b1, busy = 1'b0;
  logic wel_set = 1'b0, wel_clr = 1'b0, sr_wr_req = 1'b0, arr_wr_req = 1'b0;
  logic [7:0]  sr_wr_data = 8'h00;
  logic [13:0] arr_addr = 14'h0;
  logic sr_grant, sr_deny, arr_grant, arr_deny;
  logic [7:0] status;

  int checks = 0, errors = 0;
  bit m_wpen = 1'b0, m_wel = 1'b0;
  logic [1:0] m_bp = 2'b00;

  always #2 clk = ~clk;

  nvm_write_guard dut (.*);

  function automatic bit prot_f(input logic [1:0] bp, input logic [13:0] a);
    case (bp)
      2'b00:   return 1'b0;
      2'b01:   return a >= 14'h3000;
      2'b10:   return a >= 14'h2000;
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [7:0] exp_status();
    return {m_wpen, 3'b000, m_bp, m_wel, busy};
  endfunction

  task automatic check(input logic [3:0] exp, input string tag);
    logic [3:0] got;
    got = {sr_grant, sr_deny, arr_grant, arr_deny};
    checks++;
    if (got !== exp || status !== exp_status()) begin
      errors++;
      $display("FAIL %s: pulses %b expected %b, status %h expected %h",
               tag, got, exp, status, exp_status());
    end
  endtask

  task automatic tick(input logic [3:0] exp, input string tag);
    @(posedge clk);
    @(negedge clk);
    check(exp, tag);
  endtask

  task automatic latch(input bit s, input bit c);
    wel_set = s; wel_clr = c;
    if (c) m_wel = 1'b0; else if (s) m_wel = 1'b1;
    tick(4'b0000, "R2 latch");
    wel_set = 1'b0; wel_clr = 1'b0;
  endtask

  task automatic arr_write(input logic [13:0] a);
    bit ok;
    arr_wr_req = 1'b1; arr_addr = a;
    ok = m_wel && !busy && !prot_f(m_bp, a);
    m_wel = 1'b0;
    tick(ok ? 4'b0010 : 4'b0001, "R3 R4 R5 R9 R10 array");
    arr_wr_req = 1'b0;
  endtask

  task automatic sr_frame(input logic [7:0] d, input int gap, input int fall_at);
    bit pend;
    sel_n = 1'b0; sr_wr_req = 1'b1; sr_wr_data = d;
    pend = !(busy || !m_wel || (m_wpen && !wp_n));
    if (!pend) begin
      m_wel = 1'b0;
      tick(4'b0100, "R3 R5 R9 status reject");
    end else tick(4'b0000, "R6 R12 armed");
    sr_wr_req = 1'b0;
    for (int i = 0; i < gap; i++) begin
      if (i == fall_at && wp_n) begin
        wp_n = 1'b0;
        if (pend && m_wpen) begin
          pend = 1'b0; m_wel = 1'b0;
          tick(4'b0100, "R7 abort");
        end else tick(4'b0000, "R6 R7 fall ignored");
      end else tick(4'b0000, "R12 frame open");
    end
    sel_n = 1'b1;
    if (pend) begin
      m_wpen = d[7]; m_bp = d[3:2]; m_wel = 1'b0;
      tick(4'b1000, "R12 commit");
    end else tick(4'b0000, "R12 frame close");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(4'b0000, "R1 reset");
    rst_n = 1'b1;
    tick(4'b0000, "R1 after reset");

    latch(1, 0); latch(0, 1); latch(1, 0); latch(1, 1);
    arr_write(14'h0100);
    sr_frame(8'h00, 1, -1);

    latch(1, 0); sr_frame(8'h84, 2, -1);
    tick(4'b0000, "R11 layout");
    latch(1, 0); arr_write(14'h2FFF);
    latch(1, 0); arr_write(14'h3000);
    latch(1, 0); sr_frame(8'h88, 1, -1);
    latch(1, 0); arr_write(14'h1FFF);
    latch(1, 0); arr_write(14'h2000);
    latch(1, 0); sr_frame(8'h8C, 1, -1);
    latch(1, 0); arr_write(14'h0000);

    wp_n = 1'b0; tick(4'b0000, "R5 pin low");
    latch(1, 0); sr_frame(8'h00, 1, -1);
    latch(1, 0); arr_write(14'h0000);
    wp_n = 1'b1; tick(4'b0000, "R5 pin high");
    latch(1, 0); sr_frame(8'h00, 1, -1);
    wp_n = 1'b0; tick(4'b0000, "R6 pin low");
    latch(1, 0); sr_frame(8'h0C, 2, -1);
    latch(1, 0); arr_write(14'h1000);
    wp_n = 1'b1; tick(4'b0000, "R6 pin high");
    latch(1, 0); sr_frame(8'h80, 1, -1);
    latch(1, 0); sr_frame(8'h04, 3, 1);
    wp_n = 1'b1; tick(4'b0000, "R7 pin high");

    latch(1, 0); sr_frame(8'h88, 1, -1);
    busy = 1'b1; tick(4'b0000, "R8 engine busy");
    sel_n = 1'b0; tick(4'b0000, "R8 frame open");
    wp_n = 1'b0; tick(4'b0000, "R8 fall after commit");
    sel_n = 1'b1; tick(4'b0000, "R8 frame close");
    latch(1, 0); arr_write(14'h0010);
    latch(1, 0); sr_frame(8'h00, 1, -1);
    busy = 1'b0; wp_n = 1'b1; tick(4'b0000, "R9 idle");

    for (int n = 0; n < 600; n++) begin
      int op;
      op = int'($urandom_range(0, 5));
      case (op)
        0: latch(1'($urandom), 1'($urandom));
        1: begin
             logic [13:0] a;
             a = 14'($urandom);
             if ($urandom_range(0, 1) == 0) a = {2'($urandom), 12'($urandom_range(0, 1) ? 12'hFFF : 12'h000)};
             arr_write(a);
           end
        2: begin
             int g;
             g = int'($urandom_range(1, 4));
             if ($urandom_range(0, 3) != 0) latch(1, 0);
             sr_frame(8'($urandom), g, int'($urandom_range(0, 5)) - 1);
           end
        3: begin wp_n = 1'($urandom); tick(4'b0000, "R5 R6 pin change"); end
        4: begin busy = ($urandom_range(0, 3) == 0); tick(4'b0000, "R9 R11 busy change"); end
        default: latch(1, 0);
      endcase
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule